// File: doc/BRIEF.md
# Audio Subchannel Block Demultiplexer

This block sits after a biphase decoder on a serial digital audio link. The decoder produces one decoded subframe word per strobe, plus a flag that names the channel (left or right) and a flag that marks the first subframe of a 192-frame block. The block picks one bit out of every selected subframe, at a bit position chosen at run time, and assembles these bits into 192-bit subchannel blocks. Software or a downstream engine can then read each finished block as bytes.

There are two collection modes. In single-lane mode only left subframes contribute, so one bit is taken per stereo frame. This mode suits the channel-status stream, which is bit 30 of the word. In dual-lane mode both channels contribute, and each fills its own block. This mode suits the per-channel user-data stream. A block is aligned only by the block-start flag. A finished block is copied into a holding register and announced by a one-cycle ready pulse, while collection of the next block continues without a pause. A block-start flag that arrives before a block is full discards the partial block and raises an error pulse.

Top module: `subcode_block_demux`

## Requirements
- R1: After reset, `blk_ready` and `blk_err` are 0, the holding registers are all zero, and `rd_data` reads 0.
- R2: In single-lane mode (`cfg_dual`=0), bit `cfg_sel` of each left subframe word (`sf_left`=1) is collected. Right subframes do not affect any block.
- R3: Block bit n is the bit of the n-th collected subframe of that lane, where the subframe carrying the block-start flag is bit 0. Read byte k holds block bits 8k to 8k+7, with bit 8k in the least significant position.
- R4: In the cycle after the strobe that delivers block bit 191 of a lane, `blk_ready` is high for exactly one cycle. `blk_lane` is 0 for the left lane and 1 for the right lane.
- R5: In dual-lane mode (`cfg_dual`=1), right subframes fill a second, separate block, which is read with `rd_lane`=1. The left block is still read with `rd_lane`=0.
- R6: If a block-start flag arrives while a lane is part way through a block, `blk_err` pulses for one cycle, the partial block is dropped with no ready pulse, the holding register keeps the previous block, and a new block starts at bit 0.
- R7: Before the first block-start flag, no bits are collected and no ready pulse occurs.
- R8: The holding register changes only when a block completes, so the previous block stays readable while the next one is collected.
- R9: `rd_data` shows the byte selected by `rd_lane` and `rd_addr` one clock after they are presented.
- R10: Cycles with `sf_valid`=0 have no effect, whatever the other subframe inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | Strobe: one decoded subframe is present |
| sf_word | input | SF_W | Decoded subframe word |
| sf_left | input | 1 | 1 = left subframe, 0 = right subframe |
| sf_blk_start | input | 1 | Subframe is the first of a block |
| cfg_sel | input | SEL_W | Bit position taken from each subframe |
| cfg_dual | input | 1 | 0 = left lane only, 1 = both lanes |
| rd_lane | input | 1 | Lane of the holding register to read |
| rd_addr | input | ADDR_W | Byte index into the holding register |
| rd_data | output | 8 | Registered read byte |
| blk_ready | output | 1 | One-cycle pulse: a block was completed |
| blk_lane | output | 1 | Lane of the completed block |
| blk_err | output | 1 | One-cycle pulse: a partial block was dropped |

## Verification
The bench builds the block with a 16-bit block length, which gives two bytes per lane, and keeps the 32-bit subframe word. The short block lets the bench sweep every one of the 32 bit positions with a complete block each. It also lets it reach, in a few thousand cycles, the completion pulse, the abort on an early block-start, holding-register persistence during the next collection, and dual-lane operation. Expected bits are taken arithmetically from a hashed word sequence. Right words are set to the inverse of the left words, so any leak from the right channel in single-lane mode shows up.

// File: rtl/sc_demux_pkg.sv
package sc_demux_pkg;
  localparam int LANES = 2;
  typedef enum logic {
    LANE_LEFT  = 1'b0,
    LANE_RIGHT = 1'b1
  } lane_e;
endpackage

// File: rtl/sc_bit_pick.sv
module sc_bit_pick #(
  parameter int SF_W  = 32,
  parameter int SEL_W = $clog2(SF_W)
) (
  input  logic [SF_W-1:0]  word,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out
);
  always_comb begin
    bit_out = 1'b0;
    if (int'(sel) < SF_W) bit_out = word[sel];
  end
endmodule

// File: rtl/sc_lane.sv
module sc_lane #(
  parameter int BLOCK_BITS = 192,
  localparam int NBYTES = BLOCK_BITS / 8,
  localparam int ADDR_W = $clog2(NBYTES + 1),
  localparam int IDX_W  = $clog2(BLOCK_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              take,
  input  logic              bit_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              done,
  output logic              abort
);
  logic [BLOCK_BITS-1:0] acc, hold, acc_nxt;
  logic [IDX_W-1:0]      idx, cur;
  logic                  synced, last;

  always_comb begin
    cur          = start ? '0 : idx;
    acc_nxt      = acc;
    acc_nxt[cur] = bit_in;
    last         = (int'(cur) == BLOCK_BITS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      hold   <= '0;
      idx    <= '0;
      synced <= 1'b0;
      done   <= 1'b0;
      abort  <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      if (start) begin
        abort  <= synced && (idx != '0);
        synced <= 1'b1;
        idx    <= '0;
      end
      if (take && (synced || start)) begin
        acc <= acc_nxt;
        if (last) begin
          hold <= acc_nxt;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= cur + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    if (int'(rd_addr) < NBYTES) rd_byte = hold[{rd_addr, 3'b000} +: 8];
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst) done |-> $past(take)); // R4
  AST_ABORT_ON_START: assert property (@(posedge clk) disable iff (rst) abort |-> $past(start)); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst) int'(idx) < BLOCK_BITS); // R3
  AST_UNSYNCED_IDLE: assert property (@(posedge clk) disable iff (rst) !synced |-> (idx == '0)); // R7
endmodule

// File: rtl/subcode_block_demux.sv
module subcode_block_demux #(
  parameter int SF_W       = 32,
  parameter int SEL_W      = $clog2(SF_W),
  parameter int BLOCK_BITS = 192,
  localparam int NBYTES = BLOCK_BITS / 8,
  localparam int ADDR_W = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sf_valid,
  input  logic [SF_W-1:0]   sf_word,
  input  logic              sf_left,
  input  logic              sf_blk_start,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_dual,
  input  logic              rd_lane,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              blk_ready,
  output logic              blk_lane,
  output logic              blk_err
);
  import sc_demux_pkg::*;

  logic             picked;
  logic [LANES-1:0] start_v, take_v, done_v, abort_v;
  logic [7:0]       rb [LANES];

  sc_bit_pick #(.SF_W(SF_W), .SEL_W(SEL_W)) pick_i (
    .word(sf_word), .sel(cfg_sel), .bit_out(picked)
  );

  always_comb begin
    start_v[LANE_LEFT]  = sf_valid && sf_left && sf_blk_start;
    take_v[LANE_LEFT]   = sf_valid && sf_left;
    start_v[LANE_RIGHT] = sf_valid && sf_left && sf_blk_start && cfg_dual;
    take_v[LANE_RIGHT]  = sf_valid && !sf_left && cfg_dual;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sc_lane #(.BLOCK_BITS(BLOCK_BITS)) lane_i (
      .clk(clk), .rst(rst),
      .start(start_v[g]), .take(take_v[g]), .bit_in(picked),
      .rd_addr(rd_addr), .rd_byte(rb[g]),
      .done(done_v[g]), .abort(abort_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rb[rd_lane];
  end

  assign blk_ready = |done_v;
  assign blk_lane  = done_v[LANE_RIGHT];
  assign blk_err   = |abort_v;

  AST_READY_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(blk_ready && blk_err)); // R6
  AST_READY_AFTER_VALID: assert property (@(posedge clk) disable iff (rst) blk_ready |-> $past(sf_valid)); // R10
  AST_LANES_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(done_v)); // R4
endmodule

// File: tb/subcode_block_demux_tb_top.sv
module subcode_block_demux_tb_top;
  localparam int BB = 16;
  localparam int NB = BB / 8;
  localparam int AW = $clog2(NB + 1);

  logic clk = 0, rst = 1;
  logic sf_valid = 0, sf_left = 0, sf_blk_start = 0;
  logic [31:0] sf_word = '0;
  logic [4:0] cfg_sel = '0;
  logic cfg_dual = 0, rd_lane = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic blk_ready, blk_lane, blk_err;

  always #2.5 clk = ~clk;

  subcode_block_demux #(.BLOCK_BITS(BB)) dut_i (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_word(sf_word),
    .sf_left(sf_left), .sf_blk_start(sf_blk_start), .cfg_sel(cfg_sel),
    .cfg_dual(cfg_dual), .rd_lane(rd_lane), .rd_addr(rd_addr),
    .rd_data(rd_data), .blk_ready(blk_ready), .blk_lane(blk_lane), .blk_err(blk_err)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [BB-1:0] exp_l, exp_r;
  logic o_rdy, o_lane, o_err;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int s);
    logic [31:0] v;
    v = 32'(s) * 32'h9E3779B1;
    return v ^ (v >> 13) ^ 32'h5A5A0F0F;
  endfunction

  task automatic sf(input logic [31:0] w, input logic left, input logic bs);
    @(negedge clk);
    sf_word = w; sf_left = left; sf_blk_start = bs; sf_valid = 1;
    @(negedge clk);
    sf_valid = 0;
    o_rdy = blk_ready; o_lane = blk_lane; o_err = blk_err;
  endtask

  // one stereo frame; n = bit index, synced = ready may be expected
  task automatic frame(input int seed, input logic bs, input int n, input bit synced, input bit exp_err);
    logic [31:0] wl, wr;
    wl = mk(seed);
    wr = cfg_dual ? mk(seed + 7777) : ~wl;
    sf(wl, 1'b1, bs);
    if (synced) exp_l[n] = wl[cfg_sel];
    chk(o_rdy == (synced && n == BB-1), "R4 left ready", o_rdy, synced && n == BB-1);
    if (o_rdy) chk(o_lane == 1'b0, "R4 lane id left", o_lane, 0);
    chk(o_err == exp_err, "R6 err pulse", o_err, exp_err);
    sf(wr, 1'b0, 1'b0);
    if (synced) exp_r[n] = wr[cfg_sel];
    chk(o_rdy == (synced && cfg_dual && n == BB-1), "R5 right ready", o_rdy, synced && cfg_dual && n == BB-1);
    if (o_rdy) chk(o_lane == 1'b1, "R5 lane id right", o_lane, 1);
    chk(o_err == 1'b0, "R6 no err on right", o_err, 0);
  endtask

  task automatic rd_chk(input logic lane, input logic [BB-1:0] ev, input string req);
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      rd_lane = lane; rd_addr = AW'(k);
      @(negedge clk);
      chk(rd_data == ev[8*k +: 8], req, rd_data, ev[8*k +: 8]);
    end
  endtask

  task automatic block(input int base);
    for (int n = 0; n < BB; n++) frame(base + n, n == 0, n, 1, 0);
  endtask

  initial begin
    logic [BB-1:0] saved;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(blk_ready == 0 && blk_err == 0, "R1 outputs after reset", {blk_ready, blk_err}, 0);
    rd_chk(1'b0, '0, "R1 hold zero");

    // R7: frames before any block start
    for (int n = 0; n < 2*BB; n++) frame(900 + n, 1'b0, 0, 0, 0);
    rd_chk(1'b0, '0, "R7 nothing collected");

    // R2/R3: sweep every bit position in single-lane mode
    for (int s = 0; s < 32; s++) begin
      cfg_sel = 5'(s);
      block(1000 + 50*s);
      rd_chk(1'b0, exp_l, "R2 R3 single-lane block");
    end

    // R8: previous block readable during collection; R6: early start
    saved = exp_l;
    cfg_sel = 5'd30;
    for (int n = 0; n < 5; n++) frame(3000 + n, n == 0, n, 1, 0);
    rd_chk(1'b0, saved, "R8 hold kept mid-block");
    frame(3100, 1'b1, 0, 1, 1);
    rd_chk(1'b0, saved, "R6 partial dropped");
    for (int n = 1; n < BB; n++) frame(3100 + n, 1'b0, n, 1, 0);
    rd_chk(1'b0, exp_l, "R6 restart block");

    // R5 + R10: dual-lane with idle junk cycles
    cfg_dual = 1; cfg_sel = 5'd3;
    for (int n = 0; n < BB; n++) begin
      frame(4000 + n, n == 0, n, 1, 0);
      @(negedge clk);
      sf_word = 32'hFFFF_FFFF; sf_left = n[0]; sf_blk_start = 1; sf_valid = 0;
      @(negedge clk);
      chk(blk_ready == 0 && blk_err == 0, "R10 idle ignored", {blk_ready, blk_err}, 0);
      sf_blk_start = 0;
    end
    rd_chk(1'b0, exp_l, "R5 left lane");
    rd_chk(1'b1, exp_r, "R5 right lane");
    cfg_sel = 5'd17;
    block(5000);
    rd_chk(1'b0, exp_l, "R5 R9 left lane 2");
    rd_chk(1'b1, exp_r, "R5 R9 right lane 2");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule